// File: doc/BRIEF.md
# I2C Current-Sink DAC Control Slave

This block is the digital front end of a 10-bit current-sink DAC. It sits on an I2C bus as a write/read slave and runs on a system clock that oversamples SCL and SDA. SDA is open drain: the block sees the line level and drives only a pull-low enable. Both bus lines first pass a synchronizer and a steady-level filter, so spikes shorter than a configurable number of system clocks never reach the protocol logic.

A write transaction carries the address byte and then exactly two data bytes. Together the data bytes form a 16-bit input word. When the last of the 16 bits has arrived, the word is copied into the input register, and the DAC code and the soft power-down flag are loaded from it. A read transaction returns the input register in the same bit order and then clears it. An asynchronous active-low shutdown input forces the power-down output high no matter what the registers hold. The power-on reset puts the DAC code at zero.

Top module: `i2c_cdac_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper five address bits are 00011. The two low address bits are ignored, so 7-bit addresses 0x0C to 0x0F all match. Any other address gets no acknowledge. The eighth bit selects the direction: 0 is a write and 1 is a read. An acknowledge means sda_pull_o is high during the ninth SCL high phase.
- R2: After an address mismatch the slave releases SDA, acknowledges no byte and changes no register until the next start.
- R3: The slave asserts sda_pull_o only while the filtered SCL is low. It holds the pull through the whole ninth clock and releases it after that clock falls. This applies to the address byte and to both write data bytes.
- R4: Write data is sent high byte first, MSB first, and forms word W[15:0]. dac_code_o takes W[13:4] and the register power-down flag takes W[15]. W[14] and W[3:0] have no effect on either output.
- R5: The DAC code and the power-down flag change only once the 16th data bit has been received. A stop or a start that arrives before that point leaves both of them, and the input register, unchanged.
- R6: A read returns the input register, first the byte W[15:8] and then W[7:0], MSB first. After the second byte has been shifted out, the input register is zero. The DAC code is not changed by the read.
- R7: After reset, dac_code_o is 0, pwr_down_o is 0 while shdn_n is high, and sda_pull_o is 0. The code stays 0 until a write completes.
- R8: While shdn_n is low, pwr_down_o is 1 with no clock edge needed. When shdn_n goes high again, pwr_down_o follows the register flag.
- R9: A low pulse on SDA or SCL that lasts fewer than FILT_CYC system clocks has no effect on the transaction in progress.
- R10: A repeated start restarts address reception, whatever state the slave is in.
- R11: A data byte after the second byte of a write is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_pull_o | output | 1 | SDA pull-low enable (1 drives the line low) |
| shdn_n | input | 1 | Asynchronous active-low shutdown |
| dac_code_o | output | 10 | DAC code register |
| pwr_down_o | output | 1 | Power-down to the analog section |

## Verification
The hardest case to reach from the ports is a spike that lands in the SCL-high part of a data bit. On SDA, such a spike looks exactly like a start followed by a stop. On SCL, it looks like an extra clock. The bench reaches this case with bit tasks that take an optional glitch, injected mid-high-phase on a chosen bit of the first data byte. A spike shorter than the filter window must leave the written code exact. A longer SDA pulse must abort the transaction and keep the previous code. Address decoding is swept over all 128 addresses, and a set of arithmetic words is written, read back and read again to confirm the clear.

// File: rtl/cdac_pkg.sv
package cdac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WBYTE,
      ST_WACK,
      ST_RBYTE,
      ST_RACK,
      ST_IGNORE
   } bus_st_t;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

endpackage

// File: rtl/cdac_line_filter.sv
// Synchronizer plus steady-level filter for one bus line (R9)
module cdac_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b1;
         run_q <= '0;
      end else if (sync_q[SYNC_STAGES-1] == lvl_q) begin
         run_q <= '0;
      end else if (run_q == CW'(HOLD_CYC - 1)) begin
         lvl_q <= sync_q[SYNC_STAGES-1];
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign filt_o = lvl_q;

endmodule

// File: rtl/cdac_bus_events.sv
// Start, stop and SCL edge detection on the filtered lines
module cdac_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign start_o = scl_q & scl_f & sda_q & ~sda_f;
   assign stop_o  = scl_q & scl_f & ~sda_q & sda_f;
   assign rise_o  = scl_f & ~scl_q;
   assign fall_o  = ~scl_f & scl_q;

endmodule

// File: rtl/cdac_link_fsm.sv
// Byte-level slave engine: address match, ack, two-byte write and read
module cdac_link_fsm
   import cdac_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE    = 7'h0C,
   parameter int         ADDR_DC_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sda_f,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic              pull_o,
   output logic              commit_o,
   output logic [WORD_W-1:0] word_o,
   output logic              rd_clear_o,
   output bus_st_t           st_o,
   output logic [3:0]        cnt_o
);
   localparam logic [3:0] LAST = 4'(BYTE_W);

   bus_st_t           st;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] hi_q;
   logic [WORD_W-1:0] tx;
   logic              second, rw, macked;
   logic              hit;

   // R1: address compare, low bits optionally don't-care
   generate
      if (ADDR_DC_BITS == 0) begin : g_full_cmp
         assign hit = (sh[7:1] == ADDR_BASE);
      end else begin : g_mask_cmp
         assign hit = (sh[7:ADDR_DC_BITS+1] == ADDR_BASE[6:ADDR_DC_BITS]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         hi_q       <= '0;
         tx         <= '0;
         second     <= 1'b0;
         rw         <= 1'b0;
         macked     <= 1'b0;
         pull_o     <= 1'b0;
         commit_o   <= 1'b0;
         word_o     <= '0;
         rd_clear_o <= 1'b0;
      end else begin
         commit_o   <= 1'b0;
         rd_clear_o <= 1'b0;
         if (start_i) begin                 // R10
            st     <= ST_ADDR;
            cnt    <= '0;
            second <= 1'b0;
            pull_o <= 1'b0;
         end else if (stop_i) begin         // R5
            st     <= ST_IDLE;
            pull_o <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (rise_i) begin
                     sh  <= {sh[BYTE_W-2:0], sda_f};
                     cnt <= cnt + 1'b1;
                  end else if (fall_i && cnt == LAST) begin
                     if (hit) begin
                        pull_o <= 1'b1;
                        rw     <= sh[0];
                        st     <= ST_AACK;
                     end else begin
                        st <= ST_IGNORE;    // R2
                     end
                  end
               end
               ST_AACK: begin
                  if (fall_i) begin
                     cnt    <= '0;
                     second <= 1'b0;
                     if (rw) begin
                        pull_o <= ~rd_word_i[WORD_W-1];
                        tx     <= {rd_word_i[WORD_W-2:0], 1'b0};
                        st     <= ST_RBYTE;
                     end else begin
                        pull_o <= 1'b0;
                        st     <= ST_WBYTE;
                     end
                  end
               end
               ST_WBYTE: begin
                  if (rise_i) begin
                     sh  <= {sh[BYTE_W-2:0], sda_f};
                     cnt <= cnt + 1'b1;
                  end else if (fall_i && cnt == LAST) begin
                     pull_o <= 1'b1;
                     st     <= ST_WACK;
                     if (second) begin
                        commit_o <= 1'b1;   // R5: all 16 bits in
                        word_o   <= {hi_q, sh};
                     end else begin
                        hi_q <= sh;
                     end
                  end
               end
               ST_WACK: begin
                  if (fall_i) begin
                     pull_o <= 1'b0;
                     cnt    <= '0;
                     if (second) begin
                        st <= ST_IGNORE;    // R11
                     end else begin
                        second <= 1'b1;
                        st     <= ST_WBYTE;
                     end
                  end
               end
               ST_RBYTE: begin
                  if (rise_i) begin
                     cnt <= cnt + 1'b1;
                  end else if (fall_i) begin
                     if (cnt == LAST) begin
                        pull_o <= 1'b0;
                        st     <= ST_RACK;
                     end else begin
                        pull_o <= ~tx[WORD_W-1];
                        tx     <= {tx[WORD_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (rise_i) begin
                     macked <= ~sda_f;
                  end else if (fall_i) begin
                     cnt <= '0;
                     if (second) begin
                        rd_clear_o <= 1'b1; // R6
                        st         <= ST_IGNORE;
                     end else if (macked) begin
                        second <= 1'b1;
                        pull_o <= ~tx[WORD_W-1];
                        tx     <= {tx[WORD_W-2:0], 1'b0};
                        st     <= ST_RBYTE;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               default: ;                   // ST_IDLE, ST_IGNORE wait for start
            endcase
         end
      end
   end

   assign st_o  = st;
   assign cnt_o = cnt;

endmodule

// File: rtl/cdac_regs.sv
// Input register, DAC code register and soft power-down flag
module cdac_regs
   import cdac_pkg::*;
#(
   parameter int CODE_W   = 10,
   parameter int CODE_LSB = 4,
   parameter int PD_BIT   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rd_clear_i,
   output logic [WORD_W-1:0] in_reg_o,
   output logic [CODE_W-1:0] code_o,
   output logic              pd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_reg_o <= '0;
         code_o   <= '0;                    // R7
         pd_o     <= 1'b0;
      end else if (commit_i) begin
         in_reg_o <= word_i;
         code_o   <= word_i[CODE_LSB +: CODE_W];   // R4
         pd_o     <= word_i[PD_BIT];
      end else if (rd_clear_i) begin
         in_reg_o <= '0;                    // R6
      end
   end

endmodule

// File: rtl/i2c_cdac_slave.sv
module i2c_cdac_slave
   import cdac_pkg::*;
#(
   parameter int         SYNC_STAGES  = 2,
   parameter int         FILT_CYC     = 4,
   parameter logic [6:0] ADDR_BASE    = 7'h0C,
   parameter int         ADDR_DC_BITS = 2,
   parameter int         CODE_W       = 10,
   parameter int         CODE_LSB     = 4,
   parameter int         PD_BIT       = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              shdn_n,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              pwr_down_o
);
   localparam int N_LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("FILT_CYC must be at least 1");
      end
      if (ADDR_DC_BITS < 0 || ADDR_DC_BITS > 6) begin : g_bad_dc
         $error("ADDR_DC_BITS out of range");
      end
      if (CODE_LSB + CODE_W > PD_BIT || PD_BIT >= WORD_W) begin : g_bad_map
         $error("code field overlaps power-down bit or word");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines, filt_lines;
   logic scl_filt, sda_filt;
   logic start_evt, stop_evt, scl_rise, scl_fall;
   logic commit, rd_clear, pd_reg;
   logic [WORD_W-1:0] wr_word, in_reg;
   bus_st_t link_st;
   logic [3:0] link_cnt;

   assign raw_lines = {sda_i, scl_i};

   // R9: identical filter on each bus line
   for (genvar i = 0; i < N_LINES; i++) begin : g_filt
      cdac_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .HOLD_CYC   (FILT_CYC)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw_lines[i]),
         .filt_o(filt_lines[i])
      );
   end

   assign scl_filt = filt_lines[0];
   assign sda_filt = filt_lines[1];

   cdac_bus_events u_events (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_f  (scl_filt),
      .sda_f  (sda_filt),
      .start_o(start_evt),
      .stop_o (stop_evt),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   cdac_link_fsm #(
      .ADDR_BASE   (ADDR_BASE),
      .ADDR_DC_BITS(ADDR_DC_BITS)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_evt),
      .stop_i    (stop_evt),
      .rise_i    (scl_rise),
      .fall_i    (scl_fall),
      .sda_f     (sda_filt),
      .rd_word_i (in_reg),
      .pull_o    (sda_pull_o),
      .commit_o  (commit),
      .word_o    (wr_word),
      .rd_clear_o(rd_clear),
      .st_o      (link_st),
      .cnt_o     (link_cnt)
   );

   cdac_regs #(
      .CODE_W  (CODE_W),
      .CODE_LSB(CODE_LSB),
      .PD_BIT  (PD_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .word_i    (wr_word),
      .rd_clear_i(rd_clear),
      .in_reg_o  (in_reg),
      .code_o    (dac_code_o),
      .pd_o      (pd_reg)
   );

   // R8: shutdown overrides asynchronously
   assign pwr_down_o = pd_reg | ~shdn_n;

endmodule

// File: rtl/cdac_checker.sv
module cdac_checker
   import cdac_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              stop_evt,
   input logic              pull,
   input logic [CODE_W-1:0] code,
   input bus_st_t           st,
   input logic [3:0]        cnt
);
   AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> !scl_f);  // R3

   AST_CODE_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code) |-> pull);  // R5

   AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !pull);  // R2

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !pull);  // R5

   AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8);  // R1

endmodule

bind i2c_cdac_slave cdac_checker #(.CODE_W(CODE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_f   (scl_filt),
   .stop_evt(stop_evt),
   .pull    (sda_pull_o),
   .code    (dac_code_o),
   .st      (link_st),
   .cnt     (link_cnt)
);

// File: tb/i2c_cdac_slave_bench.sv
module i2c_cdac_slave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 10;   // quarter bit, in system clocks
   localparam int FILT       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic shdn_n = 1'b1;
   logic sda_pull;
   logic [9:0] dac_code;
   logic pwr_down;
   wire  sda_line = sda_m & ~sda_pull;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_cdac_slave #(.FILT_CYC(FILT)) u_i2c_cdac_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_pull_o(sda_pull),
      .shdn_n    (shdn_n),
      .dac_code_o(dac_code),
      .pwr_down_o(pwr_down)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; hq();
      sda_m = 1'b0; hq();
      scl_m = 1'b0; hq();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; hq();
      scl_m = 1'b1; hq();
      sda_m = 1'b0; hq();
      scl_m = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq();
      scl_m = 1'b1; hq();
      sda_m = 1'b1; hq(); hq();
   endtask

   // gmode: 0 none, 1 SDA low pulse, 2 SCL low pulse, mid high phase
   task automatic send_bit(input logic b, input int gmode, input int glen);
      sda_m = b; hq();
      scl_m = 1'b1; hq();
      if (gmode == 1) begin
         sda_m = 1'b0; repeat (glen) @(negedge clk); sda_m = b;
      end else if (gmode == 2) begin
         scl_m = 1'b0; repeat (glen) @(negedge clk); scl_m = 1'b1;
      end
      hq();
      scl_m = 1'b0; hq();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; hq();
      scl_m = 1'b1; hq();
      b = sda_line; hq();
      scl_m = 1'b0; hq();
   endtask

   task automatic write_byte(input logic [7:0] v, input int gbit, input int gmode,
                             input int glen, output logic ack);
      logic a;
      for (int i = 0; i < 8; i++)
         send_bit(v[7-i], (i == gbit) ? gmode : 0, glen);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic read_byte(output logic [7:0] v, input logic mack);
      logic b;
      for (int i = 0; i < 8; i++) begin
         recv_bit(b);
         v[7-i] = b;
      end
      send_bit(~mack, 0, 0);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [15:0] w,
                           output logic [2:0] acks);
      bus_start();
      write_byte({a, 1'b0}, -1, 0, 0, acks[0]);
      write_byte(w[15:8], -1, 0, 0, acks[1]);
      write_byte(w[7:0], -1, 0, 0, acks[2]);
      bus_stop();
   endtask

   task automatic do_read(input logic [6:0] a, output logic [15:0] w, output logic ack);
      bus_start();
      write_byte({a, 1'b1}, -1, 0, 0, ack);
      read_byte(w[15:8], 1'b1);
      read_byte(w[7:0], 1'b0);
      bus_stop();
   endtask

   function automatic int code_of(input logic [15:0] w);
      return int'((w >> 4) & 16'h03FF);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [2:0]  acks;
      logic        ack;
      logic [15:0] rw;
      logic [15:0] last_w;
      logic [7:0]  junk;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R7: reset state
      chk("R7 code after reset", dac_code, 0);
      chk("R7 pwr_down after reset", pwr_down, 0);
      chk("R7 sda released after reset", sda_pull, 0);

      // R2: mismatched address, no ack, nothing changes
      do_write(7'h20, 16'h7FF0, acks);
      chk("R2 mismatch addr ack", acks[0], 0);
      chk("R2 mismatch data ack", acks[1] | acks[2], 0);
      chk("R7 code stays zero without valid write", dac_code, 0);

      // R5: stop after first data byte aborts
      bus_start();
      write_byte(8'h18, -1, 0, 0, ack);
      write_byte(8'h3F, -1, 0, 0, ack);
      bus_stop();
      chk("R5 code unchanged after stop abort", dac_code, 0);

      // R1: exhaustive address sweep (write direction)
      for (int a = 0; a < 128; a++) begin
         bus_start();
         write_byte({7'(a), 1'b0}, -1, 0, 0, ack);
         bus_stop();
         chk($sformatf("R1 address 0x%0h ack", a), ack, ((a >> 2) == 3) ? 1 : 0);
      end

      // R4 / R6: arithmetic word sweep, using all don't-care address variants
      for (int k = 0; k < 16; k++) begin
         logic [15:0] w;
         w = 16'((k * 40503 + 7) & 16'hFFFF);
         do_write(7'h0C | 7'(k & 3), w, acks);
         chk("R3 write acks", acks, 3'b111);
         chk($sformatf("R4 code for word 0x%0h", w), dac_code, code_of(w));
         chk($sformatf("R4 pd for word 0x%0h", w), pwr_down, int'(w[15]));
         do_read(7'h0F, rw, ack);
         chk("R1 read address ack", ack, 1);
         chk($sformatf("R6 read back word 0x%0h", w), rw, w);
         do_read(7'h0C, rw, ack);
         chk("R6 second read after clear", rw, 0);
         chk("R6 code kept after read", dac_code, code_of(w));
      end

      // R4: bits 14 and 3:0 do not reach outputs
      do_write(7'h0C, 16'h0120, acks);
      do_write(7'h0D, 16'h412F, acks);
      chk("R4 bit14/low nibble ignored code", dac_code, 10'h012);
      chk("R4 bit14 does not set pd", pwr_down, 0);

      // R11: third byte not acknowledged and ignored
      bus_start();
      write_byte(8'h18, -1, 0, 0, acks[0]);
      write_byte(8'h2A, -1, 0, 0, acks[1]);
      write_byte(8'hB0, -1, 0, 0, acks[2]);
      write_byte(8'hFF, -1, 0, 0, ack);
      bus_stop();
      chk("R11 third byte nack", ack, 0);
      chk("R11 code from first two bytes", dac_code, code_of(16'h2AB0));
      last_w = 16'h2AB0;

      // R10: repeated start from ignore state to a matching write
      bus_start();
      write_byte(8'hA0, -1, 0, 0, acks[0]);
      write_byte(8'h55, -1, 0, 0, acks[1]);
      bus_rstart();
      write_byte(8'h1A, -1, 0, 0, acks[2]);
      write_byte(8'h13, -1, 0, 0, ack);
      write_byte(8'h40, -1, 0, 0, ack);
      bus_stop();
      chk("R10 foreign address nack", acks[1:0], 0);
      chk("R10 ack after repeated start", acks[2], 1);
      chk("R10 code after repeated start", dac_code, code_of(16'h1340));
      last_w = 16'h1340;

      // R5/R10: repeated start mid-write aborts; input register kept
      bus_start();
      write_byte(8'h18, -1, 0, 0, ack);
      write_byte(8'h3C, -1, 0, 0, ack);
      bus_rstart();
      write_byte(8'h19, -1, 0, 0, ack);
      read_byte(rw[15:8], 1'b1);
      read_byte(rw[7:0], 1'b0);
      bus_stop();
      chk("R5 code unchanged after restart abort", dac_code, code_of(last_w));
      chk("R5 input register unchanged after abort", rw, last_w);

      // R9: short SDA spike in first data bit high phase is filtered
      bus_start();
      write_byte(8'h18, -1, 0, 0, ack);
      write_byte(8'hA5, 0, 1, FILT - 2, acks[1]);
      write_byte(8'hC3, -1, 0, 0, acks[2]);
      bus_stop();
      chk("R9 short SDA spike code", dac_code, code_of(16'hA5C3));
      chk("R9 short SDA spike pd", pwr_down, 1);

      // R9: short SCL spike is filtered
      bus_start();
      write_byte(8'h18, -1, 0, 0, ack);
      write_byte(8'h36, 3, 2, FILT - 2, acks[1]);
      write_byte(8'h9A, -1, 0, 0, acks[2]);
      bus_stop();
      chk("R9 short SCL spike code", dac_code, code_of(16'h369A));

      // R5: long SDA pulse is a start+stop, transaction aborted
      bus_start();
      write_byte(8'h18, -1, 0, 0, ack);
      write_byte(8'h8F, 0, 1, 2 * FILT, ack);
      write_byte(8'hF0, -1, 0, 0, ack);
      bus_stop();
      chk("R5 long SDA pulse aborts", dac_code, code_of(16'h369A));

      // R8: asynchronous shutdown
      do_write(7'h0C, 16'h0550, acks);
      chk("R8 pd low before shutdown", pwr_down, 0);
      #1 shdn_n = 1'b0;
      #1 chk("R8 shutdown forces pd without clock", pwr_down, 1);
      do_write(7'h0C, 16'h0660, acks);
      chk("R8 pd held during shutdown", pwr_down, 1);
      chk("R8 code still written during shutdown", dac_code, 10'h066);
      @(negedge clk) shdn_n = 1'b1;
      #1 chk("R8 pd follows register after release", pwr_down, 0);

      finish_run();
   end

endmodule